// File: doc/BRIEF.md
# CAN Node Reset and Bus Rejoin Controller

This block sits beside a CAN protocol engine. It decides when the engine is held in reset and when the engine may take part in bus traffic again. Three things can request a reset: the chip reset, a CPU write that sets the request bit, and a rising edge on the engine's bus-off status. When a request is taken, the block gives a one-cycle abort pulse that cancels any frame in flight. It then keeps the engine idle for as long as the request bit stays set. Only the CPU can clear that bit.

When the bit is cleared, the block watches the receive line at each bit sample point. It counts runs of consecutive recessive bits and raises `synced` once the bus has been idle long enough. A chip or CPU reset needs one full run. A bus-off reset needs a set number of separate runs. The cause of the latest request is recorded when the request is taken and decides which recovery count applies. Recovery from bus-off also gives a one-cycle strobe that tells the error counters to restart. A CPU request never produces that strobe, so the counters keep their values.

The block also does three other jobs. It gates write strobes to five configuration registers: acceptance code, acceptance mask, two bit-timing registers and output control. It turns a sleep request made before synchronization into an immediate wake-up pulse. It qualifies the receive and transmit interrupts with their enables.

Top module: `can_rejoin_ctrl`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it is released, `req` is 1 and `synced`, `run_en`, `abort`, `wake`, `errcnt_clr`, `irq_rx` and `irq_tx` are all 0. The chip reset records the cause as a non-bus-off reset.
- R2: A 0-to-1 change of `bus_off` sets `req` at the next clock edge and records the cause as bus-off. A CPU write of 1 while `req` is 0 also sets `req` and records the cause as non-bus-off. In the cycle after `req` goes from 0 to 1, `abort` is 1 for exactly one cycle.
- R3: Only a CPU write of 0 (`cpu_wr`=1, `cpu_wdata`=0) clears `req`. A falling `bus_off` or any other input leaves `req` at 1. A bus-off edge in the same cycle as a CPU clear wins.
- R4: With `req` at 0 after a non-bus-off reset, `synced` rises at the clock edge that samples the 11th consecutive recessive bit. A bit is sampled when `bit_tick` is 1; recessive means `rx_bit` is 1. A dominant bit restarts the run from zero. `run_en` is 1 exactly when `synced` is 1 and `req` is 0. Setting `req` clears `synced` at the next edge.
- R5: With `req` at 0 after a bus-off reset, `synced` rises only when 128 runs of 11 recessive bits have completed. A dominant bit between runs discards only the run in progress.
- R6: `errcnt_clr` pulses for one cycle, together with the rise of `synced`, only when a bus-off recovery completes. It never pulses for recovery after a CPU request or a chip reset.
- R7: A `sleep_req` pulse while `req` is 0 and `synced` is 0 gives a one-cycle `wake` pulse in the next cycle. In any other state it gives none.
- R8: `cfg_we` is one-hot. Bit `cfg_sel` is 1 in the same cycle as `cfg_wr` only while `req` is 1 and `cfg_sel` < 5. The selects are 0 for acceptance code, 1 for acceptance mask, 2 and 3 for the two bit-timing registers, and 4 for output control. Otherwise `cfg_we` is all zero.
- R9: `irq_rx` pulses one cycle after an error-free reception pulse `rx_ok` only if `rx_ie` is 1.
- R10: `irq_tx` pulses one cycle after a successful-transmission pulse `tx_done` only if `tx_ie` is 1. Raising `tx_ie` while no `tx_done` occurs gives no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low chip reset; also a reset request source |
| cpu_wr | input | 1 | CPU write strobe for the request bit |
| cpu_wdata | input | 1 | Value written to the request bit |
| bus_off | input | 1 | Bus-off status from the engine; a rising edge requests reset |
| bit_tick | input | 1 | One-cycle strobe at each bit sample point |
| rx_bit | input | 1 | Sampled receive line, 1 = recessive |
| sleep_req | input | 1 | Sleep request pulse |
| cfg_wr | input | 1 | Configuration register write strobe |
| cfg_sel | input | SEL_W (3) | Configuration register select |
| rx_ok | input | 1 | Error-free reception pulse |
| rx_ie | input | 1 | Receive interrupt enable |
| tx_done | input | 1 | Successful transmission pulse |
| tx_ie | input | 1 | Transmit interrupt enable |
| req | output | 1 | Reset request bit |
| abort | output | 1 | One-cycle abort of the frame in progress |
| synced | output | 1 | Node synchronized to the bus |
| run_en | output | 1 | Engine may operate normally |
| errcnt_clr | output | 1 | Error-counter restart strobe after bus-off recovery |
| wake | output | 1 | Immediate wake-up pulse |
| cfg_we | output | CFG_NUM (5) | Per-register write enables |
| irq_rx | output | 1 | Receive interrupt pulse |
| irq_tx | output | 1 | Transmit interrupt pulse |

## Verification
The assertions assume that `rx_ok` and `tx_done` are single-cycle pulses. They also assume that `bit_tick` never stays high for two cycles in a row, and that `bus_off` does not toggle faster than once per cycle. The directed stimulus meets all of these:
- every pulse input is raised at one falling edge and lowered at the next;
- each sampled bit is a single tick followed by a quiet cycle;
- `bus_off` is held high for several cycles before it is released.

The checker relates the request bit only to the CPU write that preceded it. Every clear in the bench therefore comes from an explicit CPU write of 0.

// File: rtl/canrj_pkg.sv
// Shared types for the CAN rejoin controller.
// Assumes nothing beyond IEEE 1800-2017 packages.
package canrj_pkg;
    typedef enum logic {
        CAUSE_HOST   = 1'b0,   // chip reset or CPU request
        CAUSE_BUSOFF = 1'b1    // engine reached bus-off
    } rj_cause_e;
endpackage

// File: rtl/canrj_req_latch.sv
// Reset request latch: sets on chip reset, bus-off rise or CPU write of 1;
// clears only on a CPU write of 0. Records the cause and emits an abort
// pulse on every 0->1 change of the request.
// Assumes bus_off is synchronous to clk.
module canrj_req_latch
    import canrj_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cpu_wr,
    input  logic      cpu_wdata,
    input  logic      bus_off,
    output logic      req,
    output rj_cause_e cause,
    output logic      abort
);
    logic bus_off_q;
    logic req_prev;
    logic boff_rise;

    assign boff_rise = bus_off & ~bus_off_q;

    // Request bit and cause: bus-off edge outranks any CPU write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req   <= 1'b1;
            cause <= CAUSE_HOST;
        end else if (boff_rise) begin
            req   <= 1'b1;
            cause <= CAUSE_BUSOFF;
        end else if (cpu_wr) begin
            req <= cpu_wdata;
            if (cpu_wdata && !req) begin
                cause <= CAUSE_HOST;
            end
        end
    end

    // Edge history for bus-off detection and abort generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_off_q <= 1'b0;
            req_prev  <= 1'b1;
        end else begin
            bus_off_q <= bus_off;
            req_prev  <= req;
        end
    end

    assign abort = req & ~req_prev;
endmodule

// File: rtl/canrj_run_counter.sv
// Bus integration counter: counts runs of RUN_LEN recessive samples after
// the request clears. One run suffices for a host cause; BOFF_RUNS runs are
// needed after bus-off, which also yields an error-counter restart strobe.
// Assumes bit_tick marks one sample point per bit.
module canrj_run_counter
    import canrj_pkg::*;
#(
    parameter int RUN_LEN   = 11,
    parameter int BOFF_RUNS = 128
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      req,
    input  rj_cause_e cause,
    input  logic      bit_tick,
    input  logic      rx_bit,
    output logic      synced,
    output logic      errcnt_clr
);
    localparam int RUN_W = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1;
    localparam int OCC_W = (BOFF_RUNS > 1) ? $clog2(BOFF_RUNS) : 1;
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RUN_LEN - 1);
    localparam logic [OCC_W-1:0] OCC_LAST = OCC_W'(BOFF_RUNS - 1);

    logic [RUN_W-1:0] run_cnt;
    logic [OCC_W-1:0] occ_cnt;
    logic             run_done;

    assign run_done = bit_tick & rx_bit & (run_cnt == RUN_LAST);

    // Run and occurrence counting, sync flag and restart strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || req) begin
            run_cnt    <= '0;
            occ_cnt    <= '0;
            synced     <= 1'b0;
            errcnt_clr <= 1'b0;
        end else begin
            errcnt_clr <= 1'b0;
            if (!synced && bit_tick) begin
                if (!rx_bit) begin
                    run_cnt <= '0;
                end else if (run_done) begin
                    run_cnt <= '0;
                    if (cause == CAUSE_HOST) begin
                        synced <= 1'b1;
                    end else if (occ_cnt == OCC_LAST) begin
                        synced     <= 1'b1;
                        occ_cnt    <= '0;
                        errcnt_clr <= 1'b1;
                    end else begin
                        occ_cnt <= occ_cnt + 1'b1;
                    end
                end else begin
                    run_cnt <= run_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/canrj_gate.sv
// Access and interrupt gating: per-register config write enables open only
// while the request is set; wake-up, receive and transmit pulses are
// qualified and registered.
// Assumes rx_ok, tx_done and sleep_req are single-cycle pulses.
module canrj_gate #(
    parameter int CFG_NUM = 5,
    parameter int SEL_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic               synced,
    input  logic               cfg_wr,
    input  logic [SEL_W-1:0]   cfg_sel,
    input  logic               sleep_req,
    input  logic               rx_ok,
    input  logic               rx_ie,
    input  logic               tx_done,
    input  logic               tx_ie,
    output logic [CFG_NUM-1:0] cfg_we,
    output logic               wake,
    output logic               irq_rx,
    output logic               irq_tx
);
    // One decoded write enable per configuration register.
    for (genvar g = 0; g < CFG_NUM; g++) begin : g_cfg
        assign cfg_we[g] = cfg_wr & req & (cfg_sel == SEL_W'(g));
    end

    // Registered wake-up and interrupt pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake   <= 1'b0;
            irq_rx <= 1'b0;
            irq_tx <= 1'b0;
        end else begin
            wake   <= sleep_req & ~req & ~synced;
            irq_rx <= rx_ok & rx_ie;
            irq_tx <= tx_done & tx_ie;
        end
    end
endmodule

// File: rtl/can_rejoin_ctrl.sv
// Top of the CAN reset and bus rejoin controller. Holds the protocol engine
// idle while a reset request is pending, then releases it once the bus has
// been recessive long enough for the recorded reset cause.
// Assumes all inputs are synchronous to clk.
module can_rejoin_ctrl
    import canrj_pkg::*;
#(
    parameter int RUN_LEN   = 11,
    parameter int BOFF_RUNS = 128,
    parameter int CFG_NUM   = 5,
    parameter int SEL_W     = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_wr,
    input  logic               cpu_wdata,
    input  logic               bus_off,
    input  logic               bit_tick,
    input  logic               rx_bit,
    input  logic               sleep_req,
    input  logic               cfg_wr,
    input  logic [SEL_W-1:0]   cfg_sel,
    input  logic               rx_ok,
    input  logic               rx_ie,
    input  logic               tx_done,
    input  logic               tx_ie,
    output logic               req,
    output logic               abort,
    output logic               synced,
    output logic               run_en,
    output logic               errcnt_clr,
    output logic               wake,
    output logic [CFG_NUM-1:0] cfg_we,
    output logic               irq_rx,
    output logic               irq_tx
);
    rj_cause_e cause;

    canrj_req_latch i_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_wr    (cpu_wr),
        .cpu_wdata (cpu_wdata),
        .bus_off   (bus_off),
        .req       (req),
        .cause     (cause),
        .abort     (abort)
    );

    canrj_run_counter #(
        .RUN_LEN   (RUN_LEN),
        .BOFF_RUNS (BOFF_RUNS)
    ) i_run (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .cause      (cause),
        .bit_tick   (bit_tick),
        .rx_bit     (rx_bit),
        .synced     (synced),
        .errcnt_clr (errcnt_clr)
    );

    canrj_gate #(
        .CFG_NUM (CFG_NUM),
        .SEL_W   (SEL_W)
    ) i_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .synced    (synced),
        .cfg_wr    (cfg_wr),
        .cfg_sel   (cfg_sel),
        .sleep_req (sleep_req),
        .rx_ok     (rx_ok),
        .rx_ie     (rx_ie),
        .tx_done   (tx_done),
        .tx_ie     (tx_ie),
        .cfg_we    (cfg_we),
        .wake      (wake),
        .irq_rx    (irq_rx),
        .irq_tx    (irq_tx)
    );

    // The engine runs only when synchronized and not held in reset.
    assign run_en = synced & ~req;
endmodule

// File: rtl/canrj_checker.sv
// Property checker for can_rejoin_ctrl, attached by bind below.
// Assumes pulse inputs last one cycle.
module canrj_checker #(
    parameter int CFG_NUM = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cpu_wr,
    input logic               cpu_wdata,
    input logic               bus_off,
    input logic               sleep_req,
    input logic               cfg_wr,
    input logic               rx_ok,
    input logic               rx_ie,
    input logic               tx_done,
    input logic               tx_ie,
    input logic               req,
    input logic               abort,
    input logic               synced,
    input logic               errcnt_clr,
    input logic               wake,
    input logic [CFG_NUM-1:0] cfg_we,
    input logic               irq_rx,
    input logic               irq_tx
);
    a_r2_boff_sets: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_off) |=> req);

    a_r2_abort_on_set: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> req && $past(!req));

    a_r3_only_cpu_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req) |-> $past(cpu_wr && !cpu_wdata));

    a_r4_sync_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(synced) |-> $past(!req));

    a_r4_req_drops_sync: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> !synced);

    a_r6_clr_with_sync: assert property (@(posedge clk) disable iff (!rst_n)
        errcnt_clr |-> synced && $past(!synced));

    a_r7_wake_cond: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> $past(sleep_req && !req && !synced));

    a_r8_gate_open: assert property (@(posedge clk) disable iff (!rst_n)
        (|cfg_we) |-> req && cfg_wr);

    a_r8_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cfg_we));

    a_r9_rx_qual: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rx |-> $past(rx_ok && rx_ie));

    a_r10_tx_qual: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tx |-> $past(tx_done && tx_ie));
endmodule

bind can_rejoin_ctrl canrj_checker #(.CFG_NUM(CFG_NUM)) i_canrj_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_wr     (cpu_wr),
    .cpu_wdata  (cpu_wdata),
    .bus_off    (bus_off),
    .sleep_req  (sleep_req),
    .cfg_wr     (cfg_wr),
    .rx_ok      (rx_ok),
    .rx_ie      (rx_ie),
    .tx_done    (tx_done),
    .tx_ie      (tx_ie),
    .req        (req),
    .abort      (abort),
    .synced     (synced),
    .errcnt_clr (errcnt_clr),
    .wake       (wake),
    .cfg_we     (cfg_we),
    .irq_rx     (irq_rx),
    .irq_tx     (irq_tx)
);

// File: tb/test_can_rejoin_ctrl.sv
module test_can_rejoin_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_wr = 1'b0, cpu_wdata = 1'b0, bus_off = 1'b0;
    logic       bit_tick = 1'b0, rx_bit = 1'b1, sleep_req = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [2:0] cfg_sel = '0;
    logic       rx_ok = 1'b0, rx_ie = 1'b0, tx_done = 1'b0, tx_ie = 1'b0;
    logic       req, abort, synced, run_en, errcnt_clr, wake, irq_rx, irq_tx;
    logic [4:0] cfg_we;

    int n_vec = 0;
    int n_fail = 0;
    int n_clr = 0;

    always #4 clk = ~clk;

    can_rejoin_ctrl i_can_rejoin_ctrl (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
        .bus_off(bus_off), .bit_tick(bit_tick), .rx_bit(rx_bit),
        .sleep_req(sleep_req), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .rx_ok(rx_ok), .rx_ie(rx_ie), .tx_done(tx_done), .tx_ie(tx_ie),
        .req(req), .abort(abort), .synced(synced), .run_en(run_en),
        .errcnt_clr(errcnt_clr), .wake(wake), .cfg_we(cfg_we),
        .irq_rx(irq_rx), .irq_tx(irq_tx)
    );

    // Count restart strobes, sampled away from the active edge.
    always @(negedge clk) if (rst_n && errcnt_clr) n_clr++;

    task automatic check(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cpu_write(input logic v);
        @(negedge clk); cpu_wr = 1'b1; cpu_wdata = v;
        @(negedge clk); cpu_wr = 1'b0;
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk); rx_bit = b; bit_tick = 1'b1;
        @(negedge clk); bit_tick = 1'b0; rx_bit = 1'b1;
    endtask

    task automatic send_run(input int n);
        for (int i = 0; i < n; i++) send_bit(1'b1);
    endtask

    task automatic pulse_sleep_check(input int exp, input string tag);
        @(negedge clk); sleep_req = 1'b1;
        @(negedge clk); sleep_req = 1'b0;
        check(tag, wake, exp);
        @(negedge clk);
        check({tag, " one cycle"}, wake, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 req after reset", req, 1);
        check("R1 synced after reset", synced, 0);
        check("R1 run_en after reset", run_en, 0);
        check("R1 abort after reset", abort, 0);
        check("R1 pulses idle", {wake, errcnt_clr, irq_rx, irq_tx}, 0);
    endtask

    task automatic t_cfg_gate();
        @(negedge clk); cfg_wr = 1'b1; cfg_sel = 3'd2; #1;
        check("R8 enable sel 2 while req", cfg_we, 5'b00100);
        cfg_sel = 3'd4; #1;
        check("R8 enable sel 4 while req", cfg_we, 5'b10000);
        cfg_sel = 3'd6; #1;
        check("R8 sel out of range", cfg_we, 0);
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    task automatic t_host_rejoin();
        cpu_write(1'b0);
        check("R3 cpu clear", req, 0);
        @(negedge clk); cfg_wr = 1'b1; cfg_sel = 3'd1; #1;
        check("R8 blocked when req clear", cfg_we, 0);
        @(negedge clk); cfg_wr = 1'b0;
        pulse_sleep_check(1, "R7 wake before sync");
        send_run(10);
        check("R4 ten recessive not synced", synced, 0);
        send_bit(1'b0);
        send_run(10);
        check("R4 dominant restarts run", synced, 0);
        send_bit(1'b1);
        check("R4 synced after 11", synced, 1);
        check("R4 run_en after sync", run_en, 1);
        @(negedge clk);
        check("R6 no clear after host reset", n_clr, 0);
        pulse_sleep_check(0, "R7 no wake once synced");
    endtask

    task automatic t_busoff();
        @(negedge clk); bus_off = 1'b1;
        @(negedge clk);
        check("R2 bus-off sets req", req, 1);
        check("R2 abort pulse on bus-off", abort, 1);
        @(negedge clk);
        check("R2 abort one cycle", abort, 0);
        check("R4 req clears sync", synced, 0);
        repeat (2) @(negedge clk); bus_off = 1'b0;
        repeat (3) @(negedge clk);
        check("R3 bus-off release keeps req", req, 1);
        pulse_sleep_check(0, "R7 no wake while req set");
        cpu_write(1'b0);
        for (int r = 0; r < 127; r++) begin
            send_run(11);
            send_bit(1'b0);
        end
        check("R5 127 runs not synced", synced, 0);
        check("R6 no clear before 128 runs", n_clr, 0);
        send_run(11);
        check("R5 synced after 128 runs", synced, 1);
        @(negedge clk);
        check("R6 clear after bus-off recovery", n_clr, 1);
    endtask

    task automatic t_cpu_request();
        @(negedge clk); cpu_wr = 1'b1; cpu_wdata = 1'b1;
        @(negedge clk); cpu_wr = 1'b0;
        check("R2 cpu sets req", req, 1);
        check("R2 abort on cpu request", abort, 1);
        check("R4 run_en drops with req", run_en, 0);
        @(negedge clk);
        check("R2 abort one cycle cpu", abort, 0);
        cpu_write(1'b0);
        send_run(11);
        check("R4 cpu cause needs one run", synced, 1);
        @(negedge clk);
        check("R6 cpu request keeps counters", n_clr, 1);
    endtask

    task automatic t_irq();
        @(negedge clk); rx_ie = 1'b0; rx_ok = 1'b1;
        @(negedge clk); rx_ok = 1'b0;
        check("R9 rx masked", irq_rx, 0);
        rx_ie = 1'b1;
        @(negedge clk); rx_ok = 1'b1;
        @(negedge clk); rx_ok = 1'b0;
        check("R9 rx enabled", irq_rx, 1);
        @(negedge clk);
        check("R9 rx one cycle", irq_rx, 0);
        tx_ie = 1'b1;
        repeat (3) @(negedge clk);
        check("R10 enable alone no irq", irq_tx, 0);
        tx_done = 1'b1;
        @(negedge clk); tx_done = 1'b0;
        check("R10 tx after enable", irq_tx, 1);
        tx_ie = 1'b0;
        @(negedge clk); tx_done = 1'b1;
        @(negedge clk); tx_done = 1'b0;
        check("R10 tx masked", irq_tx, 0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_cfg_gate();
                t_host_rejoin();
                t_busoff();
                t_cpu_request();
                t_irq();
            end
            begin
                repeat (150000) @(posedge clk);
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule